// File: doc/BRIEF.md
# Buffered EEPROM Word Access Engine

This engine moves a buffer of 16-bit words between a host and a serial EEPROM through a single start/done command register. The command register takes one word per command. The host starts a request with a starting word offset, a word count and a direction. For every word, the engine writes one command. The command holds the word address and a start flag, and for a write it also holds the data. The engine then watches the register's done flag. Read data comes back on a valid/ready stream, and write data is taken from a valid/ready stream.

Before any command, the engine checks the request. A request with a zero count or an out-of-range offset ends at once with an error code. A request that this path cannot serve is handed to a separate serial sequencer through a one-cycle forward pulse. In that case the engine gives no completion of its own. The device must be of the SPI kind, and the last word address must fit the command address field.

For an accepted request, the engine holds a shared-access grant for the whole buffer. It requests the grant once and drops it in the cycle of the completion pulse. This happens whether the buffer succeeded, timed out or was refused the grant.

Top module: `eeword_engine`

## Requirements
- R1: A start with a word count of zero ends, one cycle later, in a one-cycle completion pulse with status 1 (bad argument). It raises no grant request and writes no command.
- R2: A start whose offset is at or above WORD_SIZE, with a nonzero count, completes with status 2 (range). It raises no grant request and writes no command. Only the starting offset is range-checked.
- R3: A start that passes R1 and R2 is forwarded when the device is not SPI, or when offset+count-1 exceeds 2^CMD_ADDR_W-1. It produces one forward pulse, with no completion pulse, no grant request and no command.
- R4: An accepted request raises the grant request once and holds it until the completion pulse, in which cycle it is low. A refusal (grant_nak_i) completes with status 4 (no grant) and writes no command.
- R5: Word k of a buffer is written as a command strobe with address offset+k. Commands go in ascending order.
- R6: For a read, the engine writes the command, waits for done, and presents the read data on the read stream. Data stays valid and stable until accepted. Words come in address order.
- R7: For a write, the engine takes one word from the write stream. It writes the command only after done has been seen high, and it waits for done again after the command before going on.
- R8: A done poll that sees no done for POLL_LIMIT cycles completes the request with status 3 (timeout). No further command of that buffer is written.
- R9: A buffer whose last word finishes completes with status 0 (ok). The completion pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start pulse, taken when idle |
| req_write | input | 1 | 1 = write buffer, 0 = read buffer |
| req_offset | input | OFF_W | Starting word offset |
| req_count | input | OFF_W | Number of words |
| dev_spi | input | 1 | Device is a SPI EEPROM |
| fwd_o | output | 1 | Request handed to the serial sequencer |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 3 | Completion code, valid with done_o |
| grant_req_o | output | 1 | Shared-access grant request |
| grant_ack_i | input | 1 | Grant given |
| grant_nak_i | input | 1 | Grant refused |
| ee_cmd_start_o | output | 1 | Command register write strobe with start bit |
| ee_cmd_write_o | output | 1 | Command targets the write register |
| ee_cmd_addr_o | output | CMD_ADDR_W | Command word address |
| ee_cmd_data_o | output | DATA_W | Command write data |
| ee_done_i | input | 1 | Register done flag |
| ee_rdata_i | input | DATA_W | Register read data field |
| wr_valid_i | input | 1 | Write word valid |
| wr_ready_o | output | 1 | Write word accepted |
| wr_data_i | input | DATA_W | Write word |
| rd_valid_o | output | 1 | Read word valid |
| rd_ready_i | input | 1 | Read word accepted |
| rd_data_o | output | DATA_W | Read word |

## Verification
A wrong word index appears on the very next command strobe as an address out of sequence. It can also appear as a missing or extra strobe before the completion pulse. A stuck or skipped state shows as a grant request that falls without a completion pulse, or a completion code that differs from the expected one. It can also show as a read word that changes while waiting for acceptance. A poll counter that does not restart shows as a timeout earlier than POLL_LIMIT cycles after a command. All of these show within one word's latency.

// File: rtl/eeword_pkg.sv
package eeword_pkg;

    localparam int OFF_W  = 16;
    localparam int DATA_W = 16;

    typedef enum logic [2:0] {
        ST_OK      = 3'd0,
        ST_BADARG  = 3'd1,
        ST_RANGE   = 3'd2,
        ST_TIMEOUT = 3'd3,
        ST_NOGRANT = 3'd4
    } status_e;

    typedef enum logic [1:0] {
        V_GO, V_BADARG, V_RANGE, V_FWD
    } verdict_e;

    typedef enum logic [3:0] {
        S_IDLE, S_FWD, S_GRANT, S_WDATA, S_PRE,
        S_ISSUE, S_POST, S_PUSH, S_DONE
    } state_e;

    typedef struct packed {
        logic             write;
        logic [OFF_W-1:0] offset;
        logic [OFF_W-1:0] count;
    } req_t;

    // last address offset+count-1 fits in aw bits (count >= 1)
    function automatic logic last_fits(input logic [OFF_W-1:0] off,
                                       input logic [OFF_W-1:0] cnt,
                                       input int aw);
        logic [OFF_W:0] last;
        last = {1'b0, off} + {1'b0, cnt} - (OFF_W+1)'(1);
        return (last >> aw) == '0;
    endfunction

endpackage

// File: rtl/eeword_guard.sv
module eeword_guard
    import eeword_pkg::*;
#(
    parameter int WORD_SIZE  = 1024,
    parameter int CMD_ADDR_W = 14
) (
    input  req_t     req,
    input  logic     dev_spi,
    output verdict_e verdict
);
    localparam logic [OFF_W:0] LIMIT = (OFF_W+1)'(WORD_SIZE);

    always_comb begin
        if (req.count == '0)
            verdict = V_BADARG;
        else if ({1'b0, req.offset} >= LIMIT)
            verdict = V_RANGE;
        else if (!dev_spi || !last_fits(req.offset, req.count, CMD_ADDR_W))
            verdict = V_FWD;
        else
            verdict = V_GO;
    end
endmodule

// File: rtl/eeword_poll.sv
module eeword_poll #(
    parameter int POLL_LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic done_i,
    output logic hit,
    output logic expired
);
    localparam int CW = $clog2(POLL_LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    assign hit     = active && done_i;
    assign expired = active && !done_i && (cnt == CW'(POLL_LIMIT - 1));

    // R8
    poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt < CW'(POLL_LIMIT)));
endmodule

// File: rtl/eeword_engine.sv
module eeword_engine
    import eeword_pkg::*;
#(
    parameter int WORD_SIZE  = 1024,
    parameter int CMD_ADDR_W = 14,
    parameter int POLL_LIMIT = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_start,
    input  logic                  req_write,
    input  logic [OFF_W-1:0]      req_offset,
    input  logic [OFF_W-1:0]      req_count,
    input  logic                  dev_spi,
    output logic                  fwd_o,
    output logic                  done_o,
    output logic [2:0]            status_o,
    output logic                  grant_req_o,
    input  logic                  grant_ack_i,
    input  logic                  grant_nak_i,
    output logic                  ee_cmd_start_o,
    output logic                  ee_cmd_write_o,
    output logic [CMD_ADDR_W-1:0] ee_cmd_addr_o,
    output logic [DATA_W-1:0]     ee_cmd_data_o,
    input  logic                  ee_done_i,
    input  logic [DATA_W-1:0]     ee_rdata_i,
    input  logic                  wr_valid_i,
    output logic                  wr_ready_o,
    input  logic [DATA_W-1:0]     wr_data_i,
    output logic                  rd_valid_o,
    input  logic                  rd_ready_i,
    output logic [DATA_W-1:0]     rd_data_o
);
    state_e           state;
    req_t             cur;
    req_t             live;
    verdict_e         verdict;
    logic [OFF_W-1:0] idx;
    logic [DATA_W-1:0] wbuf;
    logic [DATA_W-1:0] rbuf;
    status_e          stat;
    logic             poll_act, poll_hit, poll_exp;
    logic             last_word;
    state_e           word_next;
    logic [OFF_W-1:0] addr_full;

    assign live = '{write: req_write, offset: req_offset, count: req_count};

    eeword_guard #(.WORD_SIZE(WORD_SIZE), .CMD_ADDR_W(CMD_ADDR_W)) guard_i (
        .req(live), .dev_spi(dev_spi), .verdict(verdict)
    );

    assign poll_act = (state == S_PRE) || (state == S_POST);

    eeword_poll #(.POLL_LIMIT(POLL_LIMIT)) poll_i (
        .clk(clk), .rst(rst), .active(poll_act), .done_i(ee_done_i),
        .hit(poll_hit), .expired(poll_exp)
    );

    assign last_word = (idx == cur.count - OFF_W'(1));
    assign word_next = cur.write ? S_WDATA : S_ISSUE;
    assign addr_full = cur.offset + idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cur   <= '0;
            idx   <= '0;
            wbuf  <= '0;
            rbuf  <= '0;
            stat  <= ST_OK;
        end else begin
            case (state)
                S_IDLE: if (req_start) begin
                    cur <= live;
                    idx <= '0;
                    case (verdict)
                        V_BADARG: begin stat <= ST_BADARG; state <= S_DONE; end
                        V_RANGE:  begin stat <= ST_RANGE;  state <= S_DONE; end
                        V_FWD:    state <= S_FWD;
                        default:  state <= S_GRANT;
                    endcase
                end
                S_FWD: state <= S_IDLE;
                S_GRANT: begin
                    if (grant_nak_i) begin
                        stat  <= ST_NOGRANT;
                        state <= S_DONE;
                    end else if (grant_ack_i) begin
                        state <= word_next;
                    end
                end
                S_WDATA: if (wr_valid_i) begin
                    wbuf  <= wr_data_i;
                    state <= S_PRE;
                end
                S_PRE: begin
                    if (poll_hit) state <= S_ISSUE;
                    else if (poll_exp) begin
                        stat  <= ST_TIMEOUT;
                        state <= S_DONE;
                    end
                end
                S_ISSUE: state <= S_POST;
                S_POST: begin
                    if (poll_hit) begin
                        if (!cur.write) begin
                            rbuf  <= ee_rdata_i;
                            state <= S_PUSH;
                        end else if (last_word) begin
                            stat  <= ST_OK;
                            state <= S_DONE;
                        end else begin
                            idx   <= idx + OFF_W'(1);
                            state <= word_next;
                        end
                    end else if (poll_exp) begin
                        stat  <= ST_TIMEOUT;
                        state <= S_DONE;
                    end
                end
                S_PUSH: if (rd_ready_i) begin
                    if (last_word) begin
                        stat  <= ST_OK;
                        state <= S_DONE;
                    end else begin
                        idx   <= idx + OFF_W'(1);
                        state <= word_next;
                    end
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign fwd_o          = (state == S_FWD);
    assign done_o         = (state == S_DONE);
    assign status_o       = stat;
    assign grant_req_o    = (state == S_GRANT) || (state == S_WDATA) || (state == S_PRE)
                         || (state == S_ISSUE) || (state == S_POST) || (state == S_PUSH);
    assign ee_cmd_start_o = (state == S_ISSUE);
    assign ee_cmd_write_o = cur.write;
    assign ee_cmd_addr_o  = addr_full[CMD_ADDR_W-1:0];
    assign ee_cmd_data_o  = wbuf;
    assign wr_ready_o     = (state == S_WDATA);
    assign rd_valid_o     = (state == S_PUSH);
    assign rd_data_o      = rbuf;

    // R4
    cmd_under_grant_chk: assert property (@(posedge clk) disable iff (rst)
        ee_cmd_start_o |-> grant_req_o);

    // R7
    pre_poll_chk: assert property (@(posedge clk) disable iff (rst)
        (ee_cmd_start_o && ee_cmd_write_o) |-> $past(ee_done_i));

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R1
    badarg_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && status_o == 3'd1) |-> !$past(grant_req_o));
endmodule

// File: tb/eeword_engine_tb_top.sv
module eeword_engine_tb_top;
    localparam int WS    = 1024;
    localparam int AW    = 14;
    localparam int PLIM  = 20;
    localparam int LAT   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        req_start = 0, req_write = 0, dev_spi = 1;
    logic [15:0] req_offset = 0, req_count = 0;
    logic        fwd_o, done_o, grant_req_o;
    logic [2:0]  status_o;
    logic        grant_ack = 0, grant_nak = 0;
    logic        ee_cmd_start_o, ee_cmd_write_o;
    logic [AW-1:0] ee_cmd_addr_o;
    logic [15:0] ee_cmd_data_o;
    logic        ee_done;
    logic [15:0] ee_rdata;
    logic        wr_valid = 0, wr_ready_o;
    logic [15:0] wr_data = 0;
    logic        rd_valid_o, rd_ready = 0;
    logic [15:0] rd_data_o;

    eeword_engine #(.WORD_SIZE(WS), .CMD_ADDR_W(AW), .POLL_LIMIT(PLIM)) dut_i (
        .clk(clk), .rst(rst),
        .req_start(req_start), .req_write(req_write), .req_offset(req_offset),
        .req_count(req_count), .dev_spi(dev_spi), .fwd_o(fwd_o),
        .done_o(done_o), .status_o(status_o),
        .grant_req_o(grant_req_o), .grant_ack_i(grant_ack), .grant_nak_i(grant_nak),
        .ee_cmd_start_o(ee_cmd_start_o), .ee_cmd_write_o(ee_cmd_write_o),
        .ee_cmd_addr_o(ee_cmd_addr_o), .ee_cmd_data_o(ee_cmd_data_o),
        .ee_done_i(ee_done), .ee_rdata_i(ee_rdata),
        .wr_valid_i(wr_valid), .wr_ready_o(wr_ready_o), .wr_data_i(wr_data),
        .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready), .rd_data_o(rd_data_o)
    );

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    function automatic logic [15:0] init_val(input int a);
        return 16'((a * 7) ^ 16'h5A3C);
    endfunction

    // ---------------- device model ----------------
    logic [15:0] mem [0:WS-1];
    int          n_cmds = 0;
    int          stall_at = 0;
    int          dcnt;
    logic        p_wr;
    logic [AW-1:0] p_addr;
    logic [15:0] p_data;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WS; i++) mem[i] <= init_val(i);
            ee_done  <= 1'b1;
            ee_rdata <= '0;
            dcnt     <= 0;
        end else if (ee_cmd_start_o) begin
            n_cmds  <= n_cmds + 1;
            ee_done <= 1'b0;
            dcnt    <= LAT;
            p_wr    <= ee_cmd_write_o;
            p_addr  <= ee_cmd_addr_o;
            p_data  <= ee_cmd_data_o;
        end else if (!ee_done && !(stall_at != 0 && n_cmds >= stall_at)) begin
            if (dcnt == 0) begin
                ee_done <= 1'b1;
                if (p_wr) mem[int'(p_addr) % WS] <= p_data;
                else      ee_rdata <= mem[int'(p_addr) % WS];
            end else dcnt <= dcnt - 1;
        end
    end

    // ---------------- expectation queues ----------------
    int          q_addr[$];
    logic        q_wr[$];
    logic [15:0] q_data[$];
    logic [15:0] exp_rd[$];
    logic [15:0] wq[$];
    bit          nak_mode = 0;

    int  cyc = 0, gcnt = 0, n_grants = 0, fwd_cnt = 0;
    bit  wpend = 0, prev_gr = 0, prev_done = 0, seen_done = 0;
    logic [2:0] seen_status = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            // grant model
            if (grant_req_o) begin
                gcnt++;
                if (gcnt >= 2) begin
                    if (nak_mode) grant_nak = 1; else grant_ack = 1;
                end
            end else begin
                gcnt = 0; grant_ack = 0; grant_nak = 0;
            end
            // read stream
            rd_ready = (cyc % 3) != 1;
            if (rd_valid_o && rd_ready) begin
                if (exp_rd.size() == 0)
                    chk(0, "R6", "unexpected read word", int'(rd_data_o), -1);
                else begin
                    chk(rd_data_o == exp_rd[0], "R6", "read word",
                        int'(rd_data_o), int'(exp_rd[0]));
                    void'(exp_rd.pop_front());
                end
            end
            // write stream
            if (wpend) begin void'(wq.pop_front()); wpend = 0; end
            wr_valid = wq.size() > 0;
            wr_data  = (wq.size() > 0) ? wq[0] : 16'h0;
            if (wr_valid && wr_ready_o) wpend = 1;
            // command strobe
            if (ee_cmd_start_o) begin
                if (q_addr.size() == 0)
                    chk(0, "R8", "unexpected command addr", int'(ee_cmd_addr_o), -1);
                else begin
                    chk(int'(ee_cmd_addr_o) == q_addr[0], "R5", "command addr",
                        int'(ee_cmd_addr_o), q_addr[0]);
                    chk(ee_cmd_write_o == q_wr[0], "R5", "command dir",
                        int'(ee_cmd_write_o), int'(q_wr[0]));
                    if (q_wr[0])
                        chk(ee_cmd_data_o == q_data[0], "R7", "command data",
                            int'(ee_cmd_data_o), int'(q_data[0]));
                    void'(q_addr.pop_front()); void'(q_wr.pop_front());
                    void'(q_data.pop_front());
                end
            end
            // completion and grant
            if (done_o) begin
                seen_done = 1; seen_status = status_o;
                chk(!grant_req_o, "R4", "grant high at completion", int'(grant_req_o), 0);
                if (prev_done) chk(0, "R9", "completion longer than one cycle", 2, 1);
            end
            if (prev_gr && !grant_req_o && !done_o)
                chk(0, "R4", "grant dropped without completion", 0, 1);
            if (!prev_gr && grant_req_o) n_grants++;
            prev_gr   = grant_req_o;
            prev_done = done_o;
            if (fwd_o) fwd_cnt++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic start_req(input bit w, input int off, input int cnt, input bit spi);
        @(negedge clk);
        seen_done = 0;
        req_write = w; req_offset = 16'(off); req_count = 16'(cnt); dev_spi = spi;
        req_start = 1;
        @(negedge clk);
        req_start = 0;
    endtask

    task automatic wait_done(input string req, input int lim);
        int k;
        k = 0;
        while (!seen_done && k < lim) begin @(negedge clk); k++; end
        chk(seen_done, req, "completion seen", int'(seen_done), 1);
    endtask

    task automatic push_cmds(input bit w, input int off, input int cnt);
        for (int i = 0; i < cnt; i++) begin
            q_addr.push_back(off + i); q_wr.push_back(w); q_data.push_back(16'h0);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int g0, c0;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!done_o && !grant_req_o && !rd_valid_o && !wr_ready_o && !ee_cmd_start_o,
            "R9", "reset outputs idle", int'(done_o | grant_req_o | rd_valid_o), 0);

        // R1 zero count
        g0 = n_grants;
        start_req(0, 5, 0, 1);
        wait_done("R1", 10);
        chk(seen_status == 3'd1, "R1", "status bad argument", int'(seen_status), 1);
        chk(n_grants == g0, "R1", "no grant request", n_grants - g0, 0);
        idle(3);

        // R2 offset at word size
        start_req(0, WS, 2, 1);
        wait_done("R2", 10);
        chk(seen_status == 3'd2, "R2", "status range", int'(seen_status), 2);
        chk(n_grants == g0, "R2", "no grant request", n_grants - g0, 0);

        // R3 not SPI
        c0 = fwd_cnt;
        start_req(0, 3, 2, 0);
        idle(10);
        chk(fwd_cnt == c0 + 1, "R3", "forward pulse non-SPI", fwd_cnt - c0, 1);
        chk(!seen_done, "R3", "no completion when forwarded", int'(seen_done), 0);
        // R3 last address beyond 14 bits
        start_req(0, 1000, 15385, 1);
        idle(10);
        chk(fwd_cnt == c0 + 2, "R3", "forward pulse wide range", fwd_cnt - c0, 2);
        chk(n_grants == g0, "R3", "no grant request", n_grants - g0, 0);

        // R5 R6 read five words
        push_cmds(0, 10, 5);
        for (int i = 0; i < 5; i++) exp_rd.push_back(init_val(10 + i));
        start_req(0, 10, 5, 1);
        wait_done("R6", 2000);
        chk(seen_status == 3'd0, "R9", "read status ok", int'(seen_status), 0);
        chk(exp_rd.size() == 0, "R6", "all read words delivered", exp_rd.size(), 0);
        chk(n_grants == g0 + 1, "R4", "one grant per buffer", n_grants - g0, 1);

        // R7 write four words then read back
        for (int i = 0; i < 4; i++) begin
            q_addr.push_back(20 + i); q_wr.push_back(1);
            q_data.push_back(16'hC000 + 16'(i * 17));
            wq.push_back(16'hC000 + 16'(i * 17));
        end
        start_req(1, 20, 4, 1);
        wait_done("R7", 2000);
        chk(seen_status == 3'd0, "R7", "write status ok", int'(seen_status), 0);
        chk(q_addr.size() == 0, "R7", "all write commands", q_addr.size(), 0);
        idle(10);
        push_cmds(0, 20, 4);
        for (int i = 0; i < 4; i++) exp_rd.push_back(16'hC000 + 16'(i * 17));
        start_req(0, 20, 4, 1);
        wait_done("R7", 2000);
        chk(exp_rd.size() == 0, "R7", "written words read back", exp_rd.size(), 0);

        // R9 last word of the memory
        push_cmds(0, WS - 1, 1);
        exp_rd.push_back(init_val(WS - 1));
        start_req(0, WS - 1, 1, 1);
        wait_done("R9", 500);
        chk(seen_status == 3'd0, "R9", "single last word ok", int'(seen_status), 0);

        // R4 grant refused
        nak_mode = 1;
        c0 = n_cmds;
        start_req(0, 40, 3, 1);
        wait_done("R4", 100);
        chk(seen_status == 3'd4, "R4", "status no grant", int'(seen_status), 4);
        idle(5);
        chk(n_cmds == c0, "R4", "no command on refusal", n_cmds - c0, 0);
        nak_mode = 0;

        // R8 timeout on third word
        stall_at = n_cmds + 3;
        push_cmds(0, 100, 3);
        exp_rd.push_back(init_val(100)); exp_rd.push_back(init_val(101));
        start_req(0, 100, 6, 1);
        wait_done("R8", 2000);
        chk(seen_status == 3'd3, "R8", "status timeout", int'(seen_status), 3);
        idle(30);
        chk(q_addr.size() == 0, "R8", "commands before timeout", q_addr.size(), 0);
        chk(exp_rd.size() == 0, "R8", "words before timeout", exp_rd.size(), 0);
        stall_at = 0;
        idle(20);

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule